// File: doc/BRIEF.md
# Error Message Lookup Controller

This block receives fixed-width error messages from a streaming source. Each beat carries a valid flag and an error flag. Only the low 78 bits of the input word form the message; the bits above them are reserved and have no effect. A small cache remembers recent messages, so a repeated message does not start a new lookup. A static bypass input turns that filtering off.

For each message that is accepted, the block reads one 32-bit word from a sensitivity map that the user supplies. The read goes through a memory-mapped read master with a wait / datavalid handshake. The selected lanes of the returned word give a region number. Region 0 marks the error as non-critical; any other region marks it as critical and is reported on the region output.

The result flags stay set until a clear pulse or reset. A message that arrives while a lookup is still running is treated as an overrun and is reported as critical.

Top module: `elc_lookup_ctrl`

## Requirements
- R1: Only bits [77:0] of `msg_data` form the message. Bits [IN_W-1:78] are reserved: they take no part in duplicate detection, and a message that differs from a cached one only in these bits is treated as a repeat.
- R2: A beat with `msg_valid` and `msg_error` both high is dropped. It starts no lookup (`busy` stays low and `rd_req` stays low) and it is not written into the cache.
- R3: A beat with `msg_valid` high and `msg_error` low that arrives while `busy` is high sets `err_crit` on the next edge. The beat is then dropped: it starts no lookup and it is not cached.
- R4: When `cache_bypass` is low, a message that is already in the 4-entry cache starts no lookup. A message that is not in the cache is written into the next slot in round-robin order. Reset empties the cache.
- R5: When `cache_bypass` is high, every accepted message starts a lookup and is written into the cache, even if it is already there.
- R6: The read address is MAP_BASE + 4 × frame, where frame is message bits [23:8]. `rd_bytesel` is 4'b0001 while `rd_req` is high. While `rd_wait` is high, `rd_req` stays high and `rd_addr` does not change. A request is accepted on an edge where `rd_req` is high and `rd_wait` is low.
- R7: After a request is accepted, data is taken only on an edge where `rd_datavalid` is high, and only from the selected byte lanes. A lane value above MAX_REGION (15) is reduced to MAX_REGION. A value of 0 sets `err_noncrit`. Any other value sets `err_crit` and loads that value into `region_id`. The flags are sticky, so an older flag stays set.
- R8: `busy` rises on the edge after the message is accepted. It falls on the same edge where the lookup result is registered.
- R9: A `result_clear` pulse sets `err_crit`, `err_noncrit` and `region_id` to zero. If a completion or an overrun lands in the same cycle as the clear, the new result takes precedence over the clear.
- R10: Reset sets `busy`, `err_crit`, `err_noncrit`, `region_id` and `rd_req` to zero. While `busy` is low and there is no clear, the three result outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cache_bypass | input | 1 | Static; when high, repeated messages are looked up again |
| msg_data | input | IN_W (120) | Message word; bits [77:0] are the message |
| msg_valid | input | 1 | Message beat is present |
| msg_error | input | 1 | Beat is corrupt and must be dropped |
| err_noncrit | output | 1 | Last lookup hit region 0 |
| err_crit | output | 1 | A lookup hit a non-zero region, or an overrun occurred |
| region_id | output | REGION_W (4) | Region from the last critical lookup |
| result_clear | input | 1 | Clears the result outputs |
| busy | output | 1 | A lookup is in progress |
| rd_addr | output | 32 | Byte address of the map word |
| rd_req | output | 1 | Read request |
| rd_bytesel | output | 4 | Byte lanes the block uses |
| rd_wait | input | 1 | Memory stalls the request |
| rd_data | input | 32 | Map word returned by the memory |
| rd_datavalid | input | 1 | `rd_data` holds the response |

## Verification
The assertions assume that the memory side returns `rd_datavalid` only after it has accepted a request, and returns exactly one response per request. They also assume that `result_clear` and `cache_bypass` change only while `busy` is low. The bench memory model raises `rd_wait` for a random number of cycles. It drives `rd_datavalid` only after it has seen an accepted request, after a random delay. The stimulus changes the bypass input and pulses clear only between lookups. Overrun beats are sent only on the cycle right after an accepted message, so they always land inside a running lookup.

// File: rtl/elc_pkg.sv
package elc_pkg;

    // Read master sequencing: idle, request held against wait, response pending
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_REQ  = 2'd1,
        RD_RESP = 2'd2
    } rd_state_e;

endpackage

// File: rtl/elc_msg_cache.sv
module elc_msg_cache #(
    parameter int KEY_W = 120,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [KEY_W-1:0] probe,
    input  logic             store,
    output logic             hit
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][KEY_W-1:0] entry;
        logic [DEPTH-1:0]            used;
        logic [PTR_W-1:0]            ptr;
    } cache_t;

    cache_t c_d, c_q;
    logic [DEPTH-1:0] match;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
            assign match[g] = c_q.used[g] && (c_q.entry[g] == probe);
        end
    endgenerate

    assign hit = |match;

    always_comb begin
        c_d = c_q;
        if (store) begin
            c_d.entry[c_q.ptr] = probe;
            c_d.used[c_q.ptr]  = 1'b1;
            c_d.ptr = (c_q.ptr == PTR_W'(DEPTH - 1)) ? '0 : c_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    // R4: a stored slot is marked as holding a message afterwards
    a_r4_slot_filled: assert property (@(posedge clk) disable iff (rst)
        store |=> (|c_q.used));

    // R4: the fill pointer moves only when a message is written
    a_r4_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !store |=> $stable(c_q.ptr));

endmodule

// File: rtl/elc_map_reader.sv
module elc_map_reader
    import elc_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              FRAME_W    = 16,
    parameter int              MAX_REGION = 15,
    parameter int              REGION_W   = 4,
    parameter logic [ADDR_W-1:0] MAP_BASE = 'h0001_0000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [FRAME_W-1:0]  frame,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic                rd_req,
    output logic [3:0]          rd_bytesel,
    input  logic                rd_wait,
    input  logic [31:0]         rd_data,
    input  logic                rd_datavalid,
    output logic                done,
    output logic [REGION_W-1:0] region,
    output logic                busy
);
    localparam int          LANES     = (REGION_W + 7) / 8;
    localparam logic [31:0] LANE_MASK = 32'((64'd1 << (8 * LANES)) - 64'd1);
    localparam logic [3:0]  SEL       = 4'((1 << LANES) - 1);

    typedef struct packed {
        rd_state_e         state;
        logic [ADDR_W-1:0] addr;
    } rd_t;

    rd_t r_d, r_q;
    logic [31:0] kept;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            RD_IDLE: begin
                if (start) begin
                    r_d.state = RD_REQ;
                    r_d.addr  = MAP_BASE + (ADDR_W'(frame) << 2);
                end
            end
            RD_REQ: begin
                if (!rd_wait) r_d.state = RD_RESP;
            end
            RD_RESP: begin
                if (rd_datavalid) r_d.state = RD_IDLE;
            end
            default: r_d.state = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{state: RD_IDLE, addr: '0};
        else     r_q <= r_d;
    end

    assign rd_req     = (r_q.state == RD_REQ);
    assign rd_addr    = r_q.addr;
    assign rd_bytesel = rd_req ? SEL : 4'b0000;
    assign busy       = (r_q.state != RD_IDLE);
    assign done       = (r_q.state == RD_RESP) && rd_datavalid;
    assign kept       = rd_data & LANE_MASK;
    assign region     = (kept > 32'(MAX_REGION)) ? REGION_W'(MAX_REGION)
                                                 : kept[REGION_W-1:0];

    // R6: a stalled request stays presented with an unchanged address
    a_r6_hold_on_wait: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_wait) |=> (rd_req && $stable(rd_addr)));

    // R6: the byte select names the low lane while a request is out
    a_r6_bytesel: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_bytesel == 4'b0001));

    // R8: a finished response leaves the reader idle
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R8: no new request starts without a start pulse
    a_r8_start_only: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);

endmodule

// File: rtl/elc_lookup_ctrl.sv
module elc_lookup_ctrl
    import elc_pkg::*;
#(
    parameter int                IN_W       = 120,
    parameter int                PAY_W      = 78,
    parameter int                FRAME_LSB  = 8,
    parameter int                FRAME_W    = 16,
    parameter int                CACHE_N    = 4,
    parameter int                MAX_REGION = 15,
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] MAP_BASE   = 'h0001_0000,
    localparam int               REGION_W   = (MAX_REGION > 0) ? $clog2(MAX_REGION + 1) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cache_bypass,
    input  logic [IN_W-1:0]     msg_data,
    input  logic                msg_valid,
    input  logic                msg_error,
    output logic                err_noncrit,
    output logic                err_crit,
    output logic [REGION_W-1:0] region_id,
    input  logic                result_clear,
    output logic                busy,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic                rd_req,
    output logic [3:0]          rd_bytesel,
    input  logic                rd_wait,
    input  logic [31:0]         rd_data,
    input  logic                rd_datavalid
);
    localparam logic [IN_W-1:0] PAY_MASK = {{(IN_W - PAY_W){1'b0}}, {PAY_W{1'b1}}};

    typedef struct packed {
        logic                crit;
        logic                noncrit;
        logic [REGION_W-1:0] region;
    } res_t;

    res_t res_d, res_q;

    logic [IN_W-1:0]     key;
    logic                cache_hit;
    logic                beat_ok;
    logic                start;
    logic                overrun;
    logic                done;
    logic [REGION_W-1:0] looked_region;

    assign key     = msg_data & PAY_MASK;
    assign beat_ok = msg_valid && !msg_error;
    assign start   = beat_ok && !busy && (cache_bypass || !cache_hit);
    assign overrun = beat_ok && busy;

    elc_msg_cache #(
        .KEY_W (IN_W),
        .DEPTH (CACHE_N)
    ) u_cache (
        .clk   (clk),
        .rst   (rst),
        .probe (key),
        .store (start),
        .hit   (cache_hit)
    );

    elc_map_reader #(
        .ADDR_W     (ADDR_W),
        .FRAME_W    (FRAME_W),
        .MAX_REGION (MAX_REGION),
        .REGION_W   (REGION_W),
        .MAP_BASE   (MAP_BASE)
    ) u_reader (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .frame        (key[FRAME_LSB +: FRAME_W]),
        .rd_addr      (rd_addr),
        .rd_req       (rd_req),
        .rd_bytesel   (rd_bytesel),
        .rd_wait      (rd_wait),
        .rd_data      (rd_data),
        .rd_datavalid (rd_datavalid),
        .done         (done),
        .region       (looked_region),
        .busy         (busy)
    );

    // Clear first, then new events, so a same-cycle result survives the clear
    always_comb begin
        res_d = res_q;
        if (result_clear) res_d = '0;
        if (overrun) res_d.crit = 1'b1;
        if (done) begin
            if (looked_region != '0) begin
                res_d.crit   = 1'b1;
                res_d.region = looked_region;
            end else begin
                res_d.noncrit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign err_crit    = res_q.crit;
    assign err_noncrit = res_q.noncrit;
    assign region_id   = res_q.region;

    // R3: a message during a lookup raises the critical flag
    a_r3_overrun_crit: assert property (@(posedge clk) disable iff (rst)
        (busy && msg_valid && !msg_error) |=> err_crit);

    // R2: a corrupt beat on an idle block starts nothing
    a_r2_error_dropped: assert property (@(posedge clk) disable iff (rst)
        (!busy && msg_valid && msg_error) |=> !busy);

    // R8: busy falls only together with a registered result
    a_r8_busy_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (err_crit || err_noncrit));

    // R9: a clear on an idle block empties the result
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (result_clear && !busy) |=> (!err_crit && !err_noncrit && region_id == '0));

    // R10: results hold while idle without a clear
    a_r10_stable: assert property (@(posedge clk) disable iff (rst)
        (!busy && !result_clear) |=>
            ($stable(err_crit) && $stable(err_noncrit) && $stable(region_id)));

    // R7: a region id is only ever reported alongside the critical flag
    a_r7_region_crit: assert property (@(posedge clk) disable iff (rst)
        (region_id != '0) |-> err_crit);

endmodule

// File: tb/elc_lookup_ctrl_bench.sv
module elc_lookup_ctrl_bench;
    localparam logic [31:0] BASE = 32'h0001_0000;

    logic         clk = 1'b0;
    logic         rst;
    logic         cache_bypass;
    logic [119:0] msg_data;
    logic         msg_valid;
    logic         msg_error;
    logic         err_noncrit;
    logic         err_crit;
    logic [3:0]   region_id;
    logic         result_clear;
    logic         busy;
    logic [31:0]  rd_addr;
    logic         rd_req;
    logic [3:0]   rd_bytesel;
    logic         rd_wait;
    logic [31:0]  rd_data;
    logic         rd_datavalid;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    elc_lookup_ctrl u_elc_lookup_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cache_bypass (cache_bypass),
        .msg_data     (msg_data),
        .msg_valid    (msg_valid),
        .msg_error    (msg_error),
        .err_noncrit  (err_noncrit),
        .err_crit     (err_crit),
        .region_id    (region_id),
        .result_clear (result_clear),
        .busy         (busy),
        .rd_addr      (rd_addr),
        .rd_req       (rd_req),
        .rd_bytesel   (rd_bytesel),
        .rd_wait      (rd_wait),
        .rd_data      (rd_data),
        .rd_datavalid (rd_datavalid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---- reference functions ----
    function automatic logic [15:0] frame_of(int k);
        return 16'(k * 37 + 5);
    endfunction

    function automatic logic [77:0] pay_of(int k);
        return {54'(k * 123457 + 11), frame_of(k), 8'(k)};
    endfunction

    function automatic logic [31:0] map_word(logic [31:0] a);
        logic [15:0] f;
        f = 16'((a - BASE) >> 2);
        return {24'hA5C33C, (f[4] & f[5]), 3'b000, (f[3:0] ^ f[7:4])};
    endfunction

    function automatic logic [3:0] exp_region(logic [31:0] w);
        return (w[7:0] > 8'd15) ? 4'd15 : w[3:0];
    endfunction

    // ---- memory model ----
    logic [31:0] last_addr;
    logic [31:0] held_addr;
    bit   in_req, pend, prev_wait;
    int   wcnt, lat;

    always @(negedge clk) begin
        if (rst) begin
            rd_wait = 0; rd_datavalid = 0; rd_data = 0;
            in_req = 0; pend = 0; prev_wait = 0; wcnt = 0; lat = 0;
        end else begin
            if (prev_wait)
                check(rd_req && rd_addr == held_addr, "R6", "request held under wait",
                      64'(rd_addr), 64'(held_addr));
            rd_wait = 0; rd_datavalid = 0; prev_wait = 0;
            if (pend) begin
                if (lat == 0) begin
                    rd_datavalid = 1; rd_data = map_word(last_addr); pend = 0;
                end else lat--;
            end else if (rd_req) begin
                if (!in_req) begin in_req = 1; wcnt = $urandom_range(0, 3); end
                check(rd_bytesel == 4'b0001, "R6", "byte select", 64'(rd_bytesel), 64'h1);
                if (wcnt > 0) begin
                    rd_wait = 1; wcnt--; prev_wait = 1; held_addr = rd_addr;
                end else begin
                    last_addr = rd_addr; in_req = 0; pend = 1;
                    lat = $urandom_range(0, 2);
                end
            end
        end
    end

    // ---- expected-state model ----
    logic [77:0] mc [4];
    bit          mv [4];
    int          mp;
    bit          ec, en;
    logic [3:0]  er;

    function automatic bit m_hit(logic [77:0] p);
        for (int i = 0; i < 4; i++) if (mv[i] && mc[i] == p) return 1;
        return 0;
    endfunction

    task automatic m_store(logic [77:0] p);
        mc[mp] = p; mv[mp] = 1; mp = (mp + 1) % 4;
    endtask

    task automatic m_reset();
        for (int i = 0; i < 4; i++) begin mv[i] = 0; mc[i] = '0; end
        mp = 0; ec = 0; en = 0; er = 0;
    endtask

    task automatic check_flags(input string req);
        check(err_crit == ec, req, "err_crit", 64'(err_crit), 64'(ec));
        check(err_noncrit == en, req, "err_noncrit", 64'(err_noncrit), 64'(en));
        check(region_id == er, req, "region_id", 64'(region_id), 64'(er));
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (busy && n < 100) begin @(negedge clk); n++; end
        check(!busy, req, "lookup finished", 64'(busy), 64'h0);
    endtask

    task automatic apply_result(int k, input string req);
        logic [31:0] a;
        logic [3:0]  r;
        a = BASE + (32'(frame_of(k)) << 2);
        check(last_addr == a, "R6", "map address", 64'(last_addr), 64'(a));
        r = exp_region(map_word(a));
        if (r != 0) begin ec = 1; er = r; end else en = 1;
        check_flags(req);
    endtask

    function automatic logic [41:0] rsv();
        return 42'({$urandom(), $urandom()});
    endfunction

    task automatic step(int k, bit err);
        logic [77:0] p;
        bit look, was_hit;
        string req;
        p = pay_of(k);
        was_hit = m_hit(p);
        look = !err && (cache_bypass || !was_hit);
        req = err ? "R2" : (cache_bypass ? "R5" : (was_hit ? "R1" : "R4"));
        msg_data = {rsv(), p}; msg_valid = 1; msg_error = err;
        @(negedge clk);
        msg_valid = 0; msg_error = 0;
        if (look) begin
            m_store(p);
            check(busy == 1, "R8", "busy after accept", 64'(busy), 64'h1);
            wait_done("R8");
            apply_result(k, cache_bypass ? "R5" : "R7");
        end else begin
            check(!busy && !rd_req, req, "no lookup", 64'({busy, rd_req}), 64'h0);
            check_flags("R10");
        end
    endtask

    task automatic overrun_pair(int ka, int kb);
        logic [77:0] p;
        p = pay_of(ka);
        if (!(cache_bypass || !m_hit(p))) begin step(ka, 0); return; end
        msg_data = {rsv(), p}; msg_valid = 1; msg_error = 0;
        @(negedge clk);
        m_store(p);
        msg_data = {rsv(), pay_of(kb)};
        @(negedge clk);
        msg_valid = 0;
        ec = 1;
        check(err_crit == 1, "R3", "crit on overrun", 64'(err_crit), 64'h1);
        wait_done("R3");
        apply_result(ka, "R3");
    endtask

    task automatic do_clear();
        result_clear = 1;
        @(negedge clk);
        result_clear = 0;
        ec = 0; en = 0; er = 0;
        check_flags("R9");
    endtask

    // ---- watchdog ----
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; cache_bypass = 0; msg_data = '0; msg_valid = 0; msg_error = 0;
        result_clear = 0;
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10: reset state
        check(!busy && !rd_req, "R10", "idle after reset", 64'({busy, rd_req}), 64'h0);
        check_flags("R10");

        // R4/R7: first lookup, then duplicate with new reserved bits (R1)
        step(0, 0);
        step(0, 0);
        // R2: error beat dropped and not cached, then a real lookup
        step(1, 1);
        step(1, 0);
        // R9: clear
        do_clear();
        // R7: region 0 gives non-critical
        step(4, 0);
        // R7: saturated region value (k=3 lane holds 0x83)
        step(3, 0);
        do_clear();
        // R3: overrun; dropped beat not cached so it looks up later
        overrun_pair(2, 5);
        step(5, 0);
        // R4: round robin eviction of k=0 after more misses
        step(4, 0);
        step(0, 0);
        // R5: bypass forces a lookup of a cached message
        cache_bypass = 1;
        step(0, 0);
        cache_bypass = 0;

        // constrained random mix
        for (int i = 0; i < 300; i++) begin
            int op;
            int k;
            op = $urandom_range(0, 9);
            k  = $urandom_range(0, 5);
            case (op)
                6: step(k, 1);
                7: do_clear();
                8: overrun_pair(k, (k + 1) % 6);
                9: cache_bypass = ($urandom_range(0, 3) == 0);
                default: step(k, 0);
            endcase
        end

        // R4: reset empties the cache
        rst = 1;
        @(negedge clk);
        rst = 0; cache_bypass = 0;
        m_reset();
        @(negedge clk);
        step(0, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule